// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block produces the bit clock and the left/right frame clock of an I2S port that always acts as clock master. It runs on one fast system clock. Each of the two audio master clocks reaches it as a one-cycle qualifier strobe, and that strobe pulses once for every edge (half period) of its master clock. A select input picks which master clock drives the timing. A 4-bit code picks the division ratio from a fixed set that mixes powers of two with multiples of six.

The frame is two 32-bit channel slots. The frame clock changes one bit clock before the first bit of each slot, which gives the one-bit I2S delay. Two static inputs invert the bit clock and the frame clock. The generator also drives one-cycle strobes for the serializer that sits next to it: one on every data-launch edge of the bit clock, and one on the launch of the first bit of each slot.

With transfers disabled, a keep-alive input holds both clocks running and silences the strobes. A new divider code is taken up only at a frame boundary, so a ratio change never cuts a clock phase short.

Top module: `aclk_gen`

## Requirements
- R1: Codes 0..7 give ratio 1, 2, 4, 8, 16, 32, 64, 128. Codes 8..12 give ratio 6, 12, 24, 48, 96. One bit clock period lasts 2 x ratio qualifier strobes of the selected master clock.
- R2: Codes 13, 14 and 15 are reserved. While one of them is active, the clocks stay parked at their idle levels and neither strobe pulses, even with transfers enabled.
- R3: The low phase and the high phase of the bit clock each last exactly ratio strobes. With ratio 1 the bit clock toggles on every strobe and follows the master clock.
- R4: A frame is 64 bit clocks. The uninverted frame clock is low during the left slot (bits 0..31) and high during the right slot (bits 32..63). It changes on the launch edge one bit before the first bit of each slot, and bit_stb pulses in that same cycle while slot_stb does not.
- R5: slot_stb pulses for one cycle, together with bit_stb, on the launch of the first bit of each slot. Successive slot_stb pulses are 32 bit_stb pulses apart.
- R6: With bclk_inv = 0, data is launched on the falling bit-clock edge and is valid on the rising edge. bit_stb is high in the first cycle that bclk is low, and the idle level is 1. bclk_inv = 1 inverts the bclk pin, so it reads 1 when bit_stb pulses and idles at 0.
- R7: lrck_inv = 1 inverts the frame clock pin, so it reads 1 during the left slot and while idle.
- R8: With xfer_en = 0 and lr_keep = 1, bclk and lrck keep toggling while bit_stb and slot_stb stay 0.
- R9: With xfer_en = 0 and lr_keep = 0, the clocks park from the next cycle on: bclk at its idle level, lrck at its left level, both strobes 0. On restart the first launch edge, which starts the left slot, comes ratio strobes after the enable.
- R10: A divider code change while the clocks run takes effect at the next frame boundary. The old ratio governs every edge up to and including the launch of the next left slot's first bit.
- R11: src_sel = 0 times the clocks from mclk0_tick and src_sel = 1 from mclk1_tick.
- R12: During and after synchronous reset, with enables low, bclk = 1, lrck = 0 and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk0_tick | input | 1 | Edge qualifier of master clock 0 |
| mclk1_tick | input | 1 | Edge qualifier of master clock 1 |
| src_sel | input | 1 | Master clock select (0: clock 0, 1: clock 1) |
| div_code | input | 4 | Divider code |
| bclk_inv | input | 1 | Bit clock inversion |
| lrck_inv | input | 1 | Frame clock inversion |
| xfer_en | input | 1 | Transfer enable |
| lr_keep | input | 1 | Keep clocks running while transfers are off |
| bclk | output | 1 | Bit clock |
| lrck | output | 1 | Left/right frame clock |
| bit_stb | output | 1 | One-cycle strobe on each data-launch edge |
| slot_stb | output | 1 | One-cycle strobe on the first bit of each slot |

## Verification
A wrong half-period counter shows at the pins within one bit clock, as a bit_stb spacing or a bclk phase length other than the ratio. A wrong bit counter or frame-clock flip point shows within one frame, because slot_stb comes at a spacing other than 32 or lrck is at the wrong level at a slot start. A divider code taken up at the wrong time changes the bit_stb spacing before the frame boundary where the change belongs, so it appears within that frame.

// File: rtl/aclkgen_pkg.sv
package aclkgen_pkg;
  localparam int CODE_W = 4;

  // Division ratio per code; 0 marks a reserved code.
  function automatic int unsigned div_ratio(input logic [CODE_W-1:0] code);
    int unsigned r;
    if (code <= 4'd7)       r = 32'd1 << code;
    else if (code <= 4'd12) r = 32'd6 << (code - 4'd8);
    else                    r = 32'd0;
    return r;
  endfunction
endpackage

// File: rtl/aclk_code_map.sv
module aclk_code_map
  import aclkgen_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  half_len,
  output logic              code_ok
);
  int unsigned ratio;

  always_comb begin
    ratio    = div_ratio(code);
    code_ok  = (ratio != 0);
    half_len = code_ok ? ratio[CNT_W-1:0] : CNT_W'(1);
  end
endmodule

// File: rtl/aclk_edge_timer.sv
module aclk_edge_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] half_len,
  output logic             ph_q,
  output logic             fire_launch
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] hcnt_q;
  logic             edge_now;

  assign edge_now    = run && tick && (hcnt_q == half_len - ONE);
  assign fire_launch = edge_now && ph_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hcnt_q <= '0;
      ph_q   <= 1'b1;
    end else if (tick) begin
      if (edge_now) begin
        hcnt_q <= '0;
        ph_q   <= ~ph_q;
      end else begin
        hcnt_q <= hcnt_q + ONE;
      end
    end
  end

  assert_half_bound_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (hcnt_q < half_len));
endmodule

// File: rtl/aclk_frame_seq.sv
module aclk_frame_seq #(
  parameter int SLOT_BITS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic launch,
  input  logic strobe_en,
  output logic lr_q,
  output logic bit_stb_q,
  output logic slot_stb_q,
  output logic frame_wrap
);
  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int BC_W       = $clog2(FRAME_BITS);
  localparam logic [BC_W-1:0] LAST      = BC_W'(FRAME_BITS - 1);
  localparam logic [BC_W-1:0] MID_LAST  = BC_W'(SLOT_BITS - 1);
  localparam logic [BC_W-1:0] PRE_RIGHT = BC_W'(SLOT_BITS - 2);
  localparam logic [BC_W-1:0] PRE_LEFT  = BC_W'(FRAME_BITS - 2);

  logic [BC_W-1:0] bcnt_q;

  assign frame_wrap = launch && (bcnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      bcnt_q     <= LAST;
      lr_q       <= 1'b0;
      bit_stb_q  <= 1'b0;
      slot_stb_q <= 1'b0;
    end else begin
      bit_stb_q  <= launch && strobe_en;
      slot_stb_q <= 1'b0;
      if (launch) begin
        bcnt_q     <= (bcnt_q == LAST) ? '0 : bcnt_q + BC_W'(1);
        slot_stb_q <= strobe_en && ((bcnt_q == LAST) || (bcnt_q == MID_LAST));
        if (bcnt_q == PRE_RIGHT)     lr_q <= 1'b1;
        else if (bcnt_q == PRE_LEFT) lr_q <= 1'b0;
      end
    end
  end

  assert_lr_on_launch_R4: assert property (@(posedge clk) disable iff (rst)
    ((lr_q != $past(lr_q)) && $past(run) && !$past(rst)) |-> $past(launch));

  assert_slot_with_bit_R5: assert property (@(posedge clk) disable iff (rst)
    slot_stb_q |-> bit_stb_q);
endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
  import aclkgen_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int SLOT_BITS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mclk0_tick,
  input  logic              mclk1_tick,
  input  logic              src_sel,
  input  logic [CODE_W-1:0] div_code,
  input  logic              bclk_inv,
  input  logic              lrck_inv,
  input  logic              xfer_en,
  input  logic              lr_keep,
  output logic              bclk,
  output logic              lrck,
  output logic              bit_stb,
  output logic              slot_stb
);
  logic [CODE_W-1:0] act_code_q;
  logic [CNT_W-1:0]  half_len;
  logic              code_ok, running, tick;
  logic              ph_q, fire_launch, lr_q, frame_wrap;

  assign tick    = src_sel ? mclk1_tick : mclk0_tick;
  assign running = (xfer_en || lr_keep) && code_ok;

  // Active divider code: free to load while parked, otherwise only at the frame boundary.
  always_ff @(posedge clk) begin
    if (rst)                        act_code_q <= '1;
    else if (!running || frame_wrap) act_code_q <= div_code;
  end

  aclk_code_map #(.CNT_W(CNT_W)) u_map (
    .code(act_code_q), .half_len(half_len), .code_ok(code_ok)
  );

  aclk_edge_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .run(running), .tick(tick), .half_len(half_len),
    .ph_q(ph_q), .fire_launch(fire_launch)
  );

  aclk_frame_seq #(.SLOT_BITS(SLOT_BITS)) u_seq (
    .clk(clk), .rst(rst), .run(running), .launch(fire_launch), .strobe_en(xfer_en),
    .lr_q(lr_q), .bit_stb_q(bit_stb), .slot_stb_q(slot_stb), .frame_wrap(frame_wrap)
  );

  assign bclk = ph_q ^ bclk_inv;
  assign lrck = lr_q ^ lrck_inv;

  assert_code_boundary_R10: assert property (@(posedge clk) disable iff (rst)
    ((act_code_q != $past(act_code_q)) && $past(running) && !$past(rst)) |-> $past(frame_wrap));

  assert_reserved_park_R2: assert property (@(posedge clk) disable iff (rst)
    !code_ok |=> (!bit_stb && !slot_stb && ph_q));

  assert_idle_park_R9: assert property (@(posedge clk) disable iff (rst)
    (!xfer_en && !lr_keep) |=> (ph_q && !lr_q && !bit_stb));

  assert_strobe_gate_R8: assert property (@(posedge clk) disable iff (rst)
    !xfer_en |=> (!bit_stb && !slot_stb));
endmodule

// File: tb/sim_aclk_gen.sv
module sim_aclk_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mclk0_tick = 1'b1, mclk1_tick = 1'b0, src_sel = 1'b0;
  logic [3:0] div_code = 4'd0;
  logic bclk_inv = 1'b0, lrck_inv = 1'b0, xfer_en = 1'b0, lr_keep = 1'b0;
  logic bclk, lrck, bit_stb, slot_stb;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  // Stimulus/expectation table: divider code i -> expected ratio.
  localparam int RATIO_TAB [0:12] = '{1, 2, 4, 8, 16, 32, 64, 128, 6, 12, 24, 48, 96};

  always #4 clk = ~clk;
  always @(negedge clk) mclk1_tick <= ~mclk1_tick;

  aclk_gen u0 (
    .clk(clk), .rst(rst), .mclk0_tick(mclk0_tick), .mclk1_tick(mclk1_tick),
    .src_sel(src_sel), .div_code(div_code), .bclk_inv(bclk_inv), .lrck_inv(lrck_inv),
    .xfer_en(xfer_en), .lr_keep(lr_keep), .bclk(bclk), .lrck(lrck),
    .bit_stb(bit_stb), .slot_stb(slot_stb)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_bit(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!bit_stb && n < 5000);
  endtask

  task automatic wait_bclk(input logic lvl, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (bclk !== lvl && n < 5000);
  endtask

  task automatic wait_slot();
    int n = 0;
    do begin @(negedge clk); n++; end while (!slot_stb && n < 5000);
  endtask

  task automatic park();
    xfer_en = 1'b0; lr_keep = 1'b0;
    cyc(2);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int d, cnt, bad, tog_l, tog_b;
    logic prev_l, prev_b;
    cyc(5);
    // R12: state under reset
    chk("R12 bclk in reset", bclk, 1);
    chk("R12 lrck in reset", lrck, 0);
    chk("R12 strobes in reset", bit_stb | slot_stb, 0);
    rst = 1'b0;
    cyc(3);
    chk("R12 bclk after reset", bclk, 1);
    chk("R12 lrck after reset", lrck, 0);

    // R1/R3/R9: walk the ratio table
    for (int i = 0; i < 13; i++) begin
      park();
      div_code = 4'(i);
      cyc(2);
      xfer_en = 1'b1;
      wait_bit(d);
      chk($sformatf("R9 first launch code %0d", i), d, RATIO_TAB[i]);
      wait_bit(d);
      chk($sformatf("R1 period code %0d", i), d, 2 * RATIO_TAB[i]);
      chk("R6 bclk low at launch", bclk, 0);
      wait_bclk(1'b1, d);
      chk($sformatf("R3 low phase code %0d", i), d, RATIO_TAB[i]);
      wait_bclk(1'b0, d);
      chk($sformatf("R3 high phase code %0d", i), d, RATIO_TAB[i]);
      chk("R6 fall coincides with bit_stb", bit_stb, 1);
    end

    // R4/R5: frame and slot structure at ratio 1
    park();
    div_code = 4'd0;
    cyc(2);
    xfer_en = 1'b1;
    wait_slot();
    chk("R4 first slot is left", lrck, 0);
    for (int k = 0; k < 2; k++) begin
      cnt = 0;
      do begin wait_bit(d); cnt++; end while (!slot_stb && cnt < 200);
      chk("R5 bits per slot", cnt, 32);
      chk("R4 lrck level at slot start", lrck, (k == 0) ? 1 : 0);
    end
    prev_l = lrck;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (lrck == prev_l && cnt < 500);
    chk("R4 bit_stb at lrck change", bit_stb, 1);
    chk("R4 no slot_stb at lrck change", slot_stb, 0);
    wait_bit(d);
    chk("R4 slot starts one bit later", slot_stb, 1);

    // R10: divider change waits for the frame boundary
    cnt = 0;
    do begin wait_slot(); cnt++; end while (lrck != 1'b0 && cnt < 4);
    div_code = 4'd1;
    bad = 0;
    for (int k = 0; k < 64; k++) begin
      wait_bit(d);
      if (d != 2) bad++;
    end
    chk("R10 old ratio until boundary", bad, 0);
    chk("R10 boundary is left slot start", slot_stb, 1);
    wait_bit(d);
    chk("R10 new ratio after boundary", d, 4);

    // R6: inverted bit clock
    park();
    bclk_inv = 1'b1;
    div_code = 4'd0;
    cyc(1);
    chk("R6 inverted idle", bclk, 0);
    xfer_en = 1'b1;
    wait_bit(d);
    chk("R6 inverted at launch", bclk, 1);
    park();
    bclk_inv = 1'b0;

    // R7: inverted frame clock
    lrck_inv = 1'b1;
    cyc(1);
    chk("R7 inverted idle", lrck, 1);
    xfer_en = 1'b1;
    wait_slot();
    chk("R7 left slot level", lrck, 1);
    wait_slot();
    chk("R7 right slot level", lrck, 0);
    park();
    lrck_inv = 1'b0;

    // R8: keep-alive without transfers
    lr_keep = 1'b1;
    cnt = 0; tog_l = 0; tog_b = 0;
    prev_l = lrck; prev_b = bclk;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      cnt += bit_stb + slot_stb;
      if (lrck != prev_l) tog_l++;
      if (bclk != prev_b) tog_b++;
      prev_l = lrck; prev_b = bclk;
    end
    chk("R8 strobes silent", cnt, 0);
    chk("R8 lrck toggles", int'(tog_l >= 4), 1);
    chk("R8 bclk toggles", int'(tog_b >= 100), 1);

    // R9: park when both enables are low
    lr_keep = 1'b0;
    cyc(1);
    bad = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (bclk !== 1'b1 || lrck !== 1'b0 || bit_stb || slot_stb) bad++;
    end
    chk("R9 parked outputs", bad, 0);

    // R2: reserved codes
    for (int c = 13; c < 16; c++) begin
      park();
      div_code = 4'(c);
      cyc(2);
      xfer_en = 1'b1;
      bad = 0;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (bclk !== 1'b1 || lrck !== 1'b0 || bit_stb || slot_stb) bad++;
      end
      chk($sformatf("R2 reserved code %0d parks", c), bad, 0);
    end

    // R11: master clock select
    park();
    src_sel = 1'b1;
    div_code = 4'd0;
    cyc(2);
    xfer_en = 1'b1;
    wait_bit(d);
    wait_bit(d);
    chk("R11 clock 1 ratio 1", d, 4);
    park();
    div_code = 4'd1;
    cyc(2);
    xfer_en = 1'b1;
    wait_bit(d);
    wait_bit(d);
    chk("R11 clock 1 ratio 2", d, 8);
    park();

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule